// File: doc/BRIEF.md
# Sharing-Aware Victim Selector

This block chooses which way of one set in a shared cache bank to evict when a processor needs room. Each way carries a short history of the processor IDs that touched it most recently. Every hit or fill on a way pushes the accessing processor's ID into that way's history.

When a processor asks for a victim, all ways are compared against the requester's ID in a single pass. The preferred victim is a line that only the requester has touched recently. Evicting it costs no other processor a hit. If no way qualifies, the selector falls back to true least-recently-used order, which it keeps in an age matrix.

The result is registered. It appears one cycle after the request as a one-hot way vector together with its binary index. The surrounding cache controller drives the touch and fill notifications and consumes the victim. Tags, data, coherence and the private banks live elsewhere.

Top module: `svs_victim_sel`

## Requirements
- R1: After reset every way's history is empty, `victim_valid_o` is low with `victim_oh_o` all zero, and the LRU order runs from way 0 (oldest) to way 7 (newest).
- R2: `victim_valid_o` is high in exactly the cycle after a cycle with `evict_req_i` high. While it is high, `victim_oh_o` has exactly one bit set, at position `victim_idx_o`. While it is low, `victim_oh_o` is zero.
- R3: A hit (`touch_valid_i` high, `touch_fill_i` low) shifts `touch_cpu_i` into the newest cell of way `touch_way_i`. The way then keeps only its 4 most recent IDs, and older IDs drop out.
- R4: A way qualifies for a requester when every valid cell of its history equals `evict_cpu_i`. A qualifying way is chosen ahead of any LRU choice.
- R5: When several ways qualify, the lowest-numbered one is chosen.
- R6: When no way qualifies, the victim is the least recently touched way.
- R7: Any hit or fill makes the touched way the most recently used.
- R8: A fill (`touch_fill_i` high) discards the way's whole history and leaves the filler's ID as its only valid cell.
- R9: A way with an empty history never qualifies.
- R10: A victim is computed from the state before any touch applied in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| touch_valid_i | input | 1 | A hit or fill on a way this cycle |
| touch_fill_i | input | 1 | The touch is a fill (1) or a hit (0) |
| touch_way_i | input | 3 | Way being touched |
| touch_cpu_i | input | 3 | ID of the processor touching the way |
| evict_req_i | input | 1 | Victim request |
| evict_cpu_i | input | 3 | ID of the processor requesting eviction |
| victim_valid_o | output | 1 | Victim result valid |
| victim_oh_o | output | 8 | Victim way, one-hot |
| victim_idx_o | output | 3 | Victim way, binary |

## Verification
The bench targets the following corner cases:
- A way whose oldest foreign ID has just shifted out, so that it newly qualifies. A design with the wrong history depth would keep rejecting it.
- Ways with empty histories. A design that treats "no mismatch" as a match would evict these instead of the LRU way.
- Several ways that qualify at once. These expose a priority encoder that picks the highest index.
- A fill over a mixed history, which must make the way exclusively the filler's.
- A touch in the same cycle as a request. This catches a selector that reads state after the update.

A long pseudo-random run then follows. A reference model built from per-way timestamps checks every victim it produces.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int unsigned SVS_WAYS  = 8;
  localparam int unsigned SVS_CPUS  = 8;
  localparam int unsigned SVS_DEPTH = 4;

  typedef enum logic {
    PICK_OWNED = 1'b0,
    PICK_LRU   = 1'b1
  } pick_src_e;
endpackage

// File: rtl/svs_history.sv
module svs_history #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned ID_W  = 3,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic             touch_fill_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [ID_W-1:0]  touch_cpu_i,
  input  logic [ID_W-1:0]  probe_cpu_i,
  output logic [WAYS-1:0]  qual_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [DEPTH-1:0][ID_W-1:0] cell_q;
    logic [DEPTH-1:0]           vld_q;
    logic [DEPTH-1:0]           miss;
    logic                       sel;

    assign sel = touch_en_i && (touch_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q <= '0;
        vld_q  <= '0;
      end else if (sel) begin
        if (touch_fill_i) begin
          cell_q    <= '0;
          cell_q[0] <= touch_cpu_i;
          vld_q     <= DEPTH'(1);
        end else begin
          cell_q <= {cell_q[DEPTH-2:0], touch_cpu_i};
          vld_q  <= {vld_q[DEPTH-2:0], 1'b1};
        end
      end
    end

    // xor-compare each valid cell against the requester
    always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
        miss[k] = vld_q[k] && (|(cell_q[k] ^ probe_cpu_i));
      end
    end

    assign qual_o[w] = (|vld_q) && !(|miss);
  end
endmodule

// File: rtl/svs_lru.sv
module svs_lru #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAYS-1:0]  lru_oh_o
);
  // newer_q[i][j]: way i used more recently than way j
  logic [WAYS-1:0][WAYS-1:0] newer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) begin
        for (int j = 0; j < WAYS; j++) begin
          newer_q[i][j] <= (i > j);
        end
      end
    end else if (touch_en_i) begin
      for (int i = 0; i < WAYS; i++) begin
        for (int j = 0; j < WAYS; j++) begin
          if (WAY_W'(i) == touch_way_i)      newer_q[i][j] <= (i != j);
          else if (WAY_W'(j) == touch_way_i) newer_q[i][j] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < WAYS; i++) begin : g_oldest
    assign lru_oh_o[i] = ~|newer_q[i];
  end
endmodule

// File: rtl/svs_pick.sv
module svs_pick
  import svs_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  qual_i,
  input  logic [WAYS-1:0]  lru_oh_i,
  output logic [WAYS-1:0]  pick_oh_o,
  output logic [WAY_W-1:0] pick_idx_o,
  output pick_src_e        pick_src_o
);
  logic [WAYS-1:0] low_qual;

  assign low_qual   = qual_i & (~qual_i + WAYS'(1));
  assign pick_src_o = (|qual_i) ? PICK_OWNED : PICK_LRU;
  assign pick_oh_o  = (|qual_i) ? low_qual : lru_oh_i;

  always_comb begin
    pick_idx_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (pick_oh_o[i]) pick_idx_o = pick_idx_o | WAY_W'(i);
    end
  end
endmodule

// File: rtl/svs_victim_sel.sv
module svs_victim_sel
  import svs_pkg::*;
#(
  parameter int unsigned NUM_WAYS  = SVS_WAYS,
  parameter int unsigned NUM_CPUS  = SVS_CPUS,
  parameter int unsigned HIST_LEN  = SVS_DEPTH,
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS),
  localparam int unsigned ID_W     = $clog2(NUM_CPUS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                touch_valid_i,
  input  logic                touch_fill_i,
  input  logic [WAY_W-1:0]    touch_way_i,
  input  logic [ID_W-1:0]     touch_cpu_i,
  input  logic                evict_req_i,
  input  logic [ID_W-1:0]     evict_cpu_i,
  output logic                victim_valid_o,
  output logic [NUM_WAYS-1:0] victim_oh_o,
  output logic [WAY_W-1:0]    victim_idx_o
);
  logic [NUM_WAYS-1:0] qual_vec;
  logic [NUM_WAYS-1:0] lru_oh;
  logic [NUM_WAYS-1:0] pick_oh;
  logic [WAY_W-1:0]    pick_idx;
  pick_src_e           pick_src;
  pick_src_e           victim_src_q;

  svs_history #(.WAYS(NUM_WAYS), .ID_W(ID_W), .DEPTH(HIST_LEN)) u_hist (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_en_i   (touch_valid_i),
    .touch_fill_i (touch_fill_i),
    .touch_way_i  (touch_way_i),
    .touch_cpu_i  (touch_cpu_i),
    .probe_cpu_i  (evict_cpu_i),
    .qual_o       (qual_vec)
  );

  svs_lru #(.WAYS(NUM_WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_valid_i),
    .touch_way_i (touch_way_i),
    .lru_oh_o    (lru_oh)
  );

  svs_pick #(.WAYS(NUM_WAYS)) u_pick (
    .qual_i     (qual_vec),
    .lru_oh_i   (lru_oh),
    .pick_oh_o  (pick_oh),
    .pick_idx_o (pick_idx),
    .pick_src_o (pick_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_valid_o <= 1'b0;
      victim_oh_o    <= '0;
      victim_idx_o   <= '0;
      victim_src_q   <= PICK_LRU;
    end else begin
      victim_valid_o <= evict_req_i;
      victim_oh_o    <= evict_req_i ? pick_oh : '0;
      if (evict_req_i) begin
        victim_idx_o <= pick_idx;
        victim_src_q <= pick_src;
      end
    end
  end
endmodule

// File: rtl/svs_victim_sel_chk.sv
module svs_victim_sel_chk
  import svs_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             touch_valid_i,
  input logic [WAY_W-1:0] touch_way_i,
  input logic             evict_req_i,
  input logic             victim_valid_o,
  input logic [WAYS-1:0]  victim_oh_o,
  input logic [WAY_W-1:0] victim_idx_o,
  input pick_src_e        victim_src_q,
  input logic [WAYS-1:0]  qual_vec,
  input logic [WAYS-1:0]  lru_oh
);
  assert_resp_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_req_i |=> victim_valid_o);
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evict_req_i |=> !victim_valid_o);
  assert_victim_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> $countones(victim_oh_o) == 1);
  assert_idx_matches_oh_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> victim_oh_o[victim_idx_o]);
  assert_idle_oh_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !victim_valid_o |-> victim_oh_o == '0);
  assert_single_oldest_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lru_oh) == 1);
  assert_touched_not_oldest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_valid_i |=> !lru_oh[$past(touch_way_i)]);
  assert_fallback_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_req_i && qual_vec == '0) |=> victim_src_q == PICK_LRU);
  assert_owner_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_req_i && qual_vec != '0) |=> victim_src_q == PICK_OWNED);
endmodule

bind svs_victim_sel svs_victim_sel_chk #(.WAYS(NUM_WAYS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .touch_valid_i  (touch_valid_i),
  .touch_way_i    (touch_way_i),
  .evict_req_i    (evict_req_i),
  .victim_valid_o (victim_valid_o),
  .victim_oh_o    (victim_oh_o),
  .victim_idx_o   (victim_idx_o),
  .victim_src_q   (victim_src_q),
  .qual_vec       (qual_vec),
  .lru_oh         (lru_oh)
);

// File: tb/tb_svs_victim_sel.sv
`timescale 1ns/1ps
module tb_svs_victim_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       touch_valid_i = 1'b0;
  logic       touch_fill_i = 1'b0;
  logic [2:0] touch_way_i = '0;
  logic [2:0] touch_cpu_i = '0;
  logic       evict_req_i = 1'b0;
  logic [2:0] evict_cpu_i = '0;
  logic       victim_valid_o;
  logic [7:0] victim_oh_o;
  logic [2:0] victim_idx_o;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  int hist [8][4];
  bit hv   [8][4];
  int stamp[8];
  int tick;

  always #2 clk_i = ~clk_i;

  svs_victim_sel dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_victim(input int cpu);
    int best;
    for (int w = 0; w < 8; w++) begin
      bit any = 0;
      bit ok = 1;
      for (int k = 0; k < 4; k++) begin
        if (hv[w][k]) begin
          any = 1;
          if (hist[w][k] != cpu) ok = 0;
        end
      end
      if (any && ok) return w;
    end
    best = 0;
    for (int w = 1; w < 8; w++) if (stamp[w] < stamp[best]) best = w;
    return best;
  endfunction

  function automatic void model_touch(input int w, input int cpu, input bit fill);
    if (fill) begin
      for (int k = 0; k < 4; k++) begin hv[w][k] = 0; hist[w][k] = 0; end
    end else begin
      for (int k = 3; k > 0; k--) begin hv[w][k] = hv[w][k-1]; hist[w][k] = hist[w][k-1]; end
    end
    hist[w][0] = cpu;
    hv[w][0] = 1;
    tick++;
    stamp[w] = tick;
  endfunction

  // called at a falling edge; result sampled at the next falling edge
  task automatic step(input bit t, input bit f, input int tw, input int tc,
                      input bit e, input int ec, input string req);
    int ev;
    touch_valid_i = t;
    touch_fill_i  = f;
    touch_way_i   = 3'(tw);
    touch_cpu_i   = 3'(tc);
    evict_req_i   = e;
    evict_cpu_i   = 3'(ec);
    ev = e ? exp_victim(ec) : 0;
    if (t) model_touch(tw, tc, f);
    @(posedge clk_i);
    @(negedge clk_i);
    touch_valid_i = 1'b0;
    touch_fill_i  = 1'b0;
    evict_req_i   = 1'b0;
    chk(victim_valid_o == e, "R2 valid", int'(victim_valid_o), int'(e));
    if (e) begin
      chk(int'(victim_idx_o) == ev, req, int'(victim_idx_o), ev);
      chk(victim_oh_o == 8'(1 << ev), {req, " onehot"}, int'(victim_oh_o), 1 << ev);
    end else begin
      chk(victim_oh_o == '0, "R2 idle onehot", int'(victim_oh_o), 0);
    end
  endtask

  task automatic hit(input int w, input int c);
    step(1, 0, w, c, 0, 0, "");
  endtask

  task automatic ev(input int c, input string req);
    step(0, 0, 0, 0, 1, c, req);
  endtask

  initial begin
    for (int w = 0; w < 8; w++) begin
      stamp[w] = w;
      for (int k = 0; k < 4; k++) begin hist[w][k] = 0; hv[w][k] = 0; end
    end
    tick = 8;
    repeat (3) @(negedge clk_i);
    chk(victim_valid_o == 1'b0, "R1 valid in reset", int'(victim_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(victim_oh_o == '0, "R1 onehot after reset", int'(victim_oh_o), 0);
    ev(3, "R1 R9 empty set gives way 0");
    ev(0, "R9 empty history never matches");

    hit(5, 2);
    ev(2, "R4 sole owner way 5");
    ev(1, "R6 no owner falls back to oldest");
    hit(3, 2);
    ev(2, "R5 lowest owned way 3");
    hit(3, 4);
    ev(2, "R4 mixed history rejected");
    hit(3, 2); hit(3, 2); hit(3, 2);
    ev(2, "R3 four cells still hold foreign id");
    hit(3, 2);
    ev(2, "R3 foreign id shifted out");
    hit(3, 6);
    step(1, 1, 3, 6, 0, 0, "");
    ev(6, "R8 fill leaves only filler id");
    hit(0, 7); hit(1, 7); hit(2, 7);
    ev(1, "R7 touched ways become newest");
    step(1, 0, 4, 1, 1, 1, "R10 same-cycle touch not seen");
    ev(1, "R4 touch from previous cycle visible");

    // sweep: fill each way with each cpu, probe with every cpu
    for (int w = 0; w < 8; w++) begin
      for (int c = 0; c < 8; c++) begin
        step(1, 1, w, c, 0, 0, "");
        for (int p = 0; p < 8; p++) ev(p, "R8 R5 R6 fill sweep");
      end
    end

    // pseudo-random mix with a narrow cpu set to create owned ways
    for (int n = 0; n < 6000; n++) begin
      bit t = ($urandom_range(0, 3) != 0);
      bit f = ($urandom_range(0, 4) == 0);
      bit e = ($urandom_range(0, 2) == 0);
      int tc = ($urandom_range(0, 1) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 7);
      int ec = $urandom_range(0, 3);
      step(t, f, $urandom_range(0, 7), tc, e, ec, "R4 R6 R10 random mix");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule